// File: doc/BRIEF.md
# Battery Warning Interrupt and Clock Restart Controller

This block turns two active-low battery warning pins into a management interrupt request. It also decides when the CPU clock has to be forced on while that interrupt is serviced. The mid warning pin (`wrn_mid_n`) reacts to falling edges only. It is ignored in the deep power modes and while the end-of-life pin (`wrn_end_n`) is low. Clearing it takes two register accesses: a read of the interrupt control register re-arms edge detection, and a write of the status register drops the request. The low warning pin (`wrn_low_n`) is level-sensitive. It forces the CPU clock on in every power mode.

All three pins pass through a two-stage synchronizer. Three state machines follow it:

- The mid-warning machine has four states. `MW_IDLE` is armed with no request. `MW_ACTIVE` has a request and is not armed. `MW_REQ_ARMED` has a request and is re-armed. `MW_BLOCKED` has no request and is not armed.
  - A qualified falling edge moves `MW_IDLE`→`MW_ACTIVE` and `MW_REQ_ARMED`→`MW_ACTIVE`.
  - A control read moves `MW_ACTIVE`→`MW_REQ_ARMED` and `MW_BLOCKED`→`MW_IDLE`.
  - A status write moves `MW_ACTIVE`→`MW_BLOCKED` and `MW_REQ_ARMED`→`MW_IDLE`.
  - A read and a status write in the same cycle move `MW_ACTIVE`→`MW_IDLE`.
- The low-warning machine has three states: `LW_IDLE`, `LW_ACTIVE` and `LW_SPENT`.
  - A low level while enabled moves `LW_IDLE`→`LW_ACTIVE`.
  - A status write moves `LW_ACTIVE`→`LW_SPENT`. If the status write comes together with a control read while the pin is high, `LW_ACTIVE` goes straight to `LW_IDLE`.
  - A control read while the pin is high moves `LW_SPENT`→`LW_IDLE`.
- The clock-hold machine has three states: `CK_OFF`, `CK_HOLD` and `CK_ARMED`.
  - A start moves `CK_OFF`→`CK_HOLD`.
  - A qualifying control write moves `CK_HOLD`→`CK_ARMED`.
  - A refresh strobe moves `CK_ARMED`→`CK_OFF`.
  - A new start moves `CK_ARMED`→`CK_HOLD`.

Top module: `batt_warn_irq`

## Requirements
- R1: Each warning pin passes through two synchronizer flops. A falling edge on `wrn_mid_n`, applied between clock edges, sets `mid_flag` at the third rising clock edge and not at the second.
- R2: When `en_mid` is 1, the mid warning sets `mid_flag` only on a 1-to-0 transition. A pin held low, or a rising pin, never sets it again.
- R3: A mid-warning falling edge is ignored when `pwr_mode` is 3 (sleep), 4 (suspend), 5 (off), 6 or 7, or when the synchronized `wrn_end_n` is 0. Modes 0 (full speed), 1 (low speed) and 2 (doze) allow it.
- R4: A `stat_wr` pulse clears `mid_flag`. No new mid-warning edge is accepted after a `stat_wr` until a `ctl_rd` pulse has occurred. A `ctl_rd` alone re-arms edge detection and leaves `mid_flag` set.
- R5: A mid-warning event raises `clk_force_on` only if `pwr_mode` is 2 (doze) and `cpu_clk_stopped` is 1.
- R6: When `en_low` is 1, a low level on `wrn_low_n` sets `low_flag`. It raises `clk_force_on` in every power mode. Enabling while the pin is already low also triggers it.
- R7: After `stat_wr` clears `low_flag`, the low warning is re-armed only by a `ctl_rd` that occurs while the synchronized pin is high.
- R8: `clk_force_on` stays high until the first `refresh_tick` after a qualifying `ctl_wr`. Any control write qualifies for a mid-warning hold. A hold that a low-warning event started needs `ctl_wdata` equal to 0.
- R9: A qualifying `ctl_wr` and a `refresh_tick` in the same cycle do not end the hold. The hold ends at the next `refresh_tick`.
- R10: `mgmt_irq` is high exactly when (`mid_flag` and `en_mid`) or (`low_flag` and `en_low`). Flags stay latched while their enable is low.
- R11: After reset, `mgmt_irq`, `mid_flag`, `low_flag` and `clk_force_on` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrn_mid_n | input | 1 | Mid battery warning, active low, asynchronous |
| wrn_low_n | input | 1 | Low battery warning, active low, asynchronous |
| wrn_end_n | input | 1 | End-of-life indication, active low, asynchronous |
| pwr_mode | input | 3 | Current power mode code (0 full, 1 low speed, 2 doze, 3 sleep, 4 suspend, 5 off) |
| cpu_clk_stopped | input | 1 | CPU clock is currently stopped |
| refresh_tick | input | 1 | One-cycle refresh strobe |
| en_mid | input | 1 | Enable for the mid warning source |
| en_low | input | 1 | Enable for the low warning source |
| ctl_rd | input | 1 | Read strobe of the interrupt control register |
| ctl_wr | input | 1 | Write strobe of the interrupt control register |
| ctl_wdata | input | CTL_W | Data of the control register write |
| stat_wr | input | 1 | Write strobe of the status register |
| mgmt_irq | output | 1 | Management interrupt request |
| mid_flag | output | 1 | Latched mid warning request |
| low_flag | output | 1 | Latched low warning request |
| clk_force_on | output | 1 | Force the CPU clock to run |

## Verification
Random trials pick the power mode, the end-of-life level, the mid enable and the clock-stopped flag, then drop the mid pin. This separates the masking terms of the mid warning from the doze-only clock restart. Directed sequences cover the rest:
- A pin held low versus a fresh edge separates edge from level triggering.
- A status write alone, a read alone and both together separate the two halves of the clear protocol.
- A nonzero write followed by a zero write shows which write ends a low-warning hold.
- A write in the same cycle as a refresh shows the one-refresh deferral.

// File: rtl/batt_warn_pkg.sv
package batt_warn_pkg;

    typedef enum logic [2:0] {
        PM_FULL    = 3'd0,
        PM_SLOW    = 3'd1,
        PM_DOZE    = 3'd2,
        PM_SLEEP   = 3'd3,
        PM_SUSPEND = 3'd4,
        PM_OFF     = 3'd5
    } pwr_mode_e;

    typedef enum logic [1:0] {
        MW_IDLE,
        MW_ACTIVE,
        MW_REQ_ARMED,
        MW_BLOCKED
    } mw_state_e;

    typedef enum logic [1:0] {
        LW_IDLE,
        LW_ACTIVE,
        LW_SPENT
    } lw_state_e;

    typedef enum logic [1:0] {
        CK_OFF,
        CK_HOLD,
        CK_ARMED
    } ck_state_e;

    localparam int PIN_MID = 0;
    localparam int PIN_LOW = 1;
    localparam int PIN_END = 2;
    localparam int N_PINS  = 3;

    // Sleep and deeper (including unused codes) block the mid warning
    function automatic logic deep_mode(input logic [2:0] mode);
        return mode >= 3'(PM_SLEEP);
    endfunction

endpackage

// File: rtl/bwi_pin_sync.sv
module bwi_pin_sync #(
    parameter int N_PINS = 3,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_raw,
    output logic [N_PINS-1:0] pin_sync,
    output logic [N_PINS-1:0] pin_prev
);

    localparam int TOP = STAGES - 1;

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // Pins idle high, so reset to 1 to avoid a false edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[TOP-1:0], pin_raw[g]};
                prev_q  <= chain_q[TOP];
            end
        end

        assign pin_sync[g] = chain_q[TOP];
        assign pin_prev[g] = prev_q;
    end

endmodule

// File: rtl/bwi_mid_source.sv
module bwi_mid_source
    import batt_warn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic       lvl_prev,
    input  logic       end_ok,
    input  logic [2:0] mode,
    input  logic       enable,
    input  logic       ctl_rd,
    input  logic       stat_wr,
    input  logic       clk_stopped,
    output logic       flag,
    output logic       clk_start
);

    mw_state_e st_q, st_d;
    logic      edge_ok;

    assign edge_ok = enable && end_ok && !deep_mode(mode) && lvl_prev && !lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MW_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MW_IDLE: begin
                if (edge_ok) st_d = MW_ACTIVE;
            end
            MW_ACTIVE: begin
                if (ctl_rd && stat_wr) st_d = MW_IDLE;
                else if (ctl_rd)       st_d = MW_REQ_ARMED;
                else if (stat_wr)      st_d = MW_BLOCKED;
            end
            MW_REQ_ARMED: begin
                if (edge_ok)      st_d = MW_ACTIVE;
                else if (stat_wr) st_d = MW_IDLE;
            end
            MW_BLOCKED: begin
                if (ctl_rd) st_d = MW_IDLE;
            end
            default: st_d = MW_IDLE;
        endcase
    end

    always_comb begin
        flag      = (st_q == MW_ACTIVE) || (st_q == MW_REQ_ARMED);
        clk_start = edge_ok && ((st_q == MW_IDLE) || (st_q == MW_REQ_ARMED))
                    && (mode == 3'(PM_DOZE)) && clk_stopped;
    end

endmodule

// File: rtl/bwi_low_source.sv
module bwi_low_source
    import batt_warn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic enable,
    input  logic ctl_rd,
    input  logic stat_wr,
    output logic flag,
    output logic clk_start
);

    lw_state_e st_q, st_d;
    logic      trig;

    assign trig = enable && !lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LW_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LW_IDLE: begin
                if (trig) st_d = LW_ACTIVE;
            end
            LW_ACTIVE: begin
                if (stat_wr) st_d = (ctl_rd && lvl) ? LW_IDLE : LW_SPENT;
            end
            LW_SPENT: begin
                if (ctl_rd && lvl) st_d = LW_IDLE;
            end
            default: st_d = LW_IDLE;
        endcase
    end

    always_comb begin
        flag      = (st_q == LW_ACTIVE);
        clk_start = trig && (st_q == LW_IDLE);
    end

endmodule

// File: rtl/bwi_clk_hold.sv
module bwi_clk_hold
    import batt_warn_pkg::*;
#(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_mid,
    input  logic             start_low,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             refresh_tick,
    output logic             force_on
);

    ck_state_e st_q, st_d;
    logic      strict_q, strict_d;
    logic      any_start, wr_zero, qual_wr;

    assign any_start = start_mid || start_low;
    assign wr_zero   = (ctl_wdata == '0);
    assign qual_wr   = ctl_wr && (wr_zero || !strict_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= CK_OFF;
            strict_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            strict_q <= strict_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CK_OFF: begin
                if (any_start) st_d = CK_HOLD;
            end
            CK_HOLD: begin
                // a refresh in the same cycle as the write is not counted
                if (!any_start && qual_wr) st_d = CK_ARMED;
            end
            CK_ARMED: begin
                if (any_start)         st_d = CK_HOLD;
                else if (refresh_tick) st_d = CK_OFF;
            end
            default: st_d = CK_OFF;
        endcase
    end

    always_comb begin
        if (st_d == CK_OFF) strict_d = 1'b0;
        else                strict_d = strict_q || start_low;
        force_on = (st_q != CK_OFF);
    end

endmodule

// File: rtl/batt_warn_irq.sv
module batt_warn_irq
    import batt_warn_pkg::*;
#(
    parameter int CTL_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrn_mid_n,
    input  logic             wrn_low_n,
    input  logic             wrn_end_n,
    input  logic [2:0]       pwr_mode,
    input  logic             cpu_clk_stopped,
    input  logic             refresh_tick,
    input  logic             en_mid,
    input  logic             en_low,
    input  logic             ctl_rd,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             stat_wr,
    output logic             mgmt_irq,
    output logic             mid_flag,
    output logic             low_flag,
    output logic             clk_force_on
);

    logic [N_PINS-1:0] raw, syn, prv;
    logic              mid_start, low_start;

    always_comb begin
        raw          = '1;
        raw[PIN_MID] = wrn_mid_n;
        raw[PIN_LOW] = wrn_low_n;
        raw[PIN_END] = wrn_end_n;
    end

    bwi_pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (raw),
        .pin_sync (syn),
        .pin_prev (prv)
    );

    bwi_mid_source u_mid (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl         (syn[PIN_MID]),
        .lvl_prev    (prv[PIN_MID]),
        .end_ok      (syn[PIN_END]),
        .mode        (pwr_mode),
        .enable      (en_mid),
        .ctl_rd      (ctl_rd),
        .stat_wr     (stat_wr),
        .clk_stopped (cpu_clk_stopped),
        .flag        (mid_flag),
        .clk_start   (mid_start)
    );

    bwi_low_source u_low (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (syn[PIN_LOW]),
        .enable    (en_low),
        .ctl_rd    (ctl_rd),
        .stat_wr   (stat_wr),
        .flag      (low_flag),
        .clk_start (low_start)
    );

    bwi_clk_hold #(.CTL_W(CTL_W)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_mid    (mid_start),
        .start_low    (low_start),
        .ctl_wr       (ctl_wr),
        .ctl_wdata    (ctl_wdata),
        .refresh_tick (refresh_tick),
        .force_on     (clk_force_on)
    );

    assign mgmt_irq = (mid_flag && en_mid) || (low_flag && en_low);

    // prv[PIN_LOW] and prv[PIN_END] are not needed by any source
    logic unused_prev;
    assign unused_prev = ^{prv[PIN_LOW], prv[PIN_END]};

endmodule

// File: rtl/batt_warn_irq_chk.sv
module batt_warn_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] pwr_mode,
    input logic       en_mid,
    input logic       stat_wr,
    input logic       refresh_tick,
    input logic       mgmt_irq,
    input logic       mid_flag,
    input logic       low_flag,
    input logic       clk_force_on
);

    // R10
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_irq |-> (mid_flag || low_flag));

    // R3
    mid_mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mid_flag) |-> ($past(pwr_mode) <= 3'd2 && $past(en_mid)));

    // R4
    mid_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mid_flag) |-> $past(stat_wr));

    // R8
    force_end_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_force_on) |-> $past(refresh_tick));

    // R6
    low_forces_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_flag) |-> clk_force_on);

endmodule

bind batt_warn_irq batt_warn_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_mode     (pwr_mode),
    .en_mid       (en_mid),
    .stat_wr      (stat_wr),
    .refresh_tick (refresh_tick),
    .mgmt_irq     (mgmt_irq),
    .mid_flag     (mid_flag),
    .low_flag     (low_flag),
    .clk_force_on (clk_force_on)
);

// File: tb/batt_warn_irq_bench.sv
module batt_warn_irq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wrn_mid_n = 1'b1, wrn_low_n = 1'b1, wrn_end_n = 1'b1;
    logic [2:0] pwr_mode = 3'd0;
    logic       cpu_clk_stopped = 1'b0, refresh_tick = 1'b0;
    logic       en_mid = 1'b1, en_low = 1'b1;
    logic       ctl_rd = 1'b0, ctl_wr = 1'b0, stat_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       mgmt_irq, mid_flag, low_flag, clk_force_on;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    batt_warn_irq u_batt_warn_irq (
        .clk(clk), .rst_n(rst_n), .wrn_mid_n(wrn_mid_n), .wrn_low_n(wrn_low_n),
        .wrn_end_n(wrn_end_n), .pwr_mode(pwr_mode), .cpu_clk_stopped(cpu_clk_stopped),
        .refresh_tick(refresh_tick), .en_mid(en_mid), .en_low(en_low),
        .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_wr(stat_wr),
        .mgmt_irq(mgmt_irq), .mid_flag(mid_flag), .low_flag(low_flag),
        .clk_force_on(clk_force_on)
    );

    function automatic bit mid_accepts(input bit [2:0] mode, input bit end_n, input bit en);
        return en && end_n && (mode <= 3'd2);
    endfunction

    function automatic bit mid_forces(input bit [2:0] mode, input bit stopped);
        return (mode == 3'd2) && stopped;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rd();     ctl_rd = 1; cyc(1); ctl_rd = 0; endtask
    task automatic pulse_stat();   stat_wr = 1; cyc(1); stat_wr = 0; endtask
    task automatic pulse_rd_stat(); ctl_rd = 1; stat_wr = 1; cyc(1); ctl_rd = 0; stat_wr = 0; endtask
    task automatic pulse_ref();    refresh_tick = 1; cyc(1); refresh_tick = 0; endtask
    task automatic pulse_wr(input logic [7:0] d);
        ctl_wr = 1; ctl_wdata = d; cyc(1); ctl_wr = 0; ctl_wdata = 8'h00;
    endtask

    task automatic mid_edge();
        wrn_mid_n = 1; cyc(4); wrn_mid_n = 0; cyc(5);
    endtask

    task automatic drop_force();
        pulse_wr(8'h00); pulse_ref();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (R1..R11 run): actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1BADB0D));
        cyc(3);
        chk("R11 irq after reset", mgmt_irq, 0);
        chk("R11 mid_flag after reset", mid_flag, 0);
        chk("R11 low_flag after reset", low_flag, 0);
        chk("R11 force after reset", clk_force_on, 0);
        rst_n = 1;
        cyc(3);

        // R1 synchronizer latency
        wrn_mid_n = 0;
        cyc(2);
        chk("R1 not yet after 2 edges", mid_flag, 0);
        cyc(1);
        chk("R1 set at third edge", mid_flag, 1);
        chk("R10 irq follows flag", mgmt_irq, 1);
        chk("R5 no force in full mode", clk_force_on, 0);

        // R2 steady low does not retrigger
        pulse_rd_stat();
        cyc(5);
        chk("R2 steady low no retrigger", mid_flag, 0);
        wrn_mid_n = 1; cyc(5);
        chk("R2 rising edge no trigger", mid_flag, 0);

        // R4 clear protocol
        mid_edge();
        chk("R4 fired", mid_flag, 1);
        pulse_stat();
        chk("R4 status write clears", mid_flag, 0);
        mid_edge();
        chk("R4 not re-armed before read", mid_flag, 0);
        pulse_rd();
        mid_edge();
        chk("R4 fires after read", mid_flag, 1);
        pulse_rd();
        chk("R4 read alone keeps request", mid_flag, 1);
        pulse_stat();
        chk("R4 status clears after read", mid_flag, 0);
        mid_edge();
        chk("R4 armed after read then status", mid_flag, 1);
        pulse_rd_stat();

        // R5 / R8 / R9 clock hold from mid warning
        pwr_mode = 3'd2; cpu_clk_stopped = 1;
        mid_edge();
        chk("R5 doze stopped forces clock", clk_force_on, 1);
        pulse_ref();
        chk("R8 refresh without write keeps force", clk_force_on, 1);
        pulse_wr(8'hA5);
        chk("R8 write alone keeps force", clk_force_on, 1);
        pulse_ref();
        chk("R8 refresh after write ends force", clk_force_on, 0);
        pulse_rd_stat();
        mid_edge();
        chk("R5 forced again", clk_force_on, 1);
        ctl_wr = 1; ctl_wdata = 8'h3C; refresh_tick = 1; cyc(1);
        ctl_wr = 0; ctl_wdata = 0; refresh_tick = 0;
        chk("R9 same-cycle write and refresh keeps force", clk_force_on, 1);
        pulse_ref();
        chk("R9 next refresh ends force", clk_force_on, 0);
        pulse_rd_stat();
        cpu_clk_stopped = 0;
        mid_edge();
        chk("R5 running clock not forced", clk_force_on, 0);
        pulse_rd_stat();
        pwr_mode = 3'd0;

        // R6 / R8 low warning in sleep
        pwr_mode = 3'd3;
        wrn_low_n = 0; cyc(5);
        chk("R6 low flag in sleep", low_flag, 1);
        chk("R6 force in sleep", clk_force_on, 1);
        chk("R10 irq from low", mgmt_irq, 1);
        pulse_wr(8'h01); pulse_ref();
        chk("R8 nonzero write keeps low hold", clk_force_on, 1);
        pulse_wr(8'h00); pulse_ref();
        chk("R8 zero write then refresh ends low hold", clk_force_on, 0);

        // R10 enable masks request but flag stays
        en_low = 0; cyc(1);
        chk("R10 irq masked by enable", mgmt_irq, 0);
        chk("R10 flag stays latched", low_flag, 1);
        en_low = 1; cyc(1);

        // R7 re-arm rule
        pulse_stat();
        chk("R7 status clears low flag", low_flag, 0);
        pulse_rd(); cyc(3);
        chk("R7 read while low does not re-arm", low_flag, 0);
        wrn_low_n = 1; cyc(4);
        pulse_rd(); cyc(2);
        chk("R7 high pin no trigger", low_flag, 0);
        wrn_low_n = 0; cyc(5);
        chk("R7 re-armed fires", low_flag, 1);
        drop_force();
        wrn_low_n = 1; cyc(4);
        pulse_stat(); pulse_rd();

        // R6 enable while low
        en_low = 0; wrn_low_n = 0; cyc(5);
        chk("R6 disabled no flag", low_flag, 0);
        chk("R6 disabled no force", clk_force_on, 0);
        en_low = 1; cyc(2);
        chk("R6 enable while low triggers", low_flag, 1);
        drop_force();
        wrn_low_n = 1; cyc(4);
        pulse_stat(); pulse_rd();
        pwr_mode = 3'd0;

        // Random trials: R3 / R5 / R10
        for (int t = 0; t < 60; t++) begin
            bit [2:0] m  = 3'($urandom % 8);
            bit       e4 = ($urandom % 4) != 0;
            bit       en = ($urandom % 4) != 0;
            bit       st = ($urandom % 2) != 0;
            bit       ex;
            pwr_mode = m; wrn_end_n = e4; en_mid = en; cpu_clk_stopped = st;
            mid_edge();
            ex = mid_accepts(m, e4, en);
            chk("R3 random mid gating", mid_flag, ex);
            chk("R10 random irq", mgmt_irq, ex);
            chk("R5 random force", clk_force_on, ex && mid_forces(m, st));
            pulse_rd_stat();
            drop_force();
            wrn_mid_n = 1; wrn_end_n = 1; en_mid = 1; pwr_mode = 0; cyc(4);
            chk("R4 random cleanup", mid_flag, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule